// File: doc/BRIEF.md
# Serial Converter Frame Master

This block is the host-side master for an eight-channel, twelve-bit serial analogue-to-digital converter. A single start strobe makes it run one frame. It pulls chip select low, produces sixteen serial clock periods and then releases chip select. During that frame it sends a fresh eight-bit control word on the data-in line and collects sixteen bits from the converter's data-out line.

The converter works one frame behind the host. The channel written during a frame chooses what is converted in the next frame. The block therefore tags each twelve-bit result with the channel it sent in the previous frame. After a reset no earlier channel exists, so the first result carries a tag marked not valid.

A half-period divider sets the serial clock rate. The divider value is captured at each start, and a value that would make a frame too slow is refused. Chip select then stays high for at least one full serial clock period before the next frame may begin.

Top module: `sadc_host`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy and done are 0, result and res_chan are 0 and res_tag_valid is 0. The stored half-period is MAX_HALF.
- R2: When start is seen while idle, cs_n goes low in the next cycle. It stays low through exactly 16 sclk rising edges and then returns high. sclk is 0 whenever cs_n is 1.
- R3: Let D be the active half-period. From the cs_n fall to the first sclk rise is D cycles. Every sclk high phase and every low phase is D cycles long. From the 16th sclk fall to the cs_n rise is D cycles. Together these give a 50% duty cycle.
- R4: half_div is sampled only when start is accepted. It is used only when it lies in 1..MAX_HALF, where MAX_HALF = LIMIT_CYCLES/32 (195 by default). A value outside that range leaves the previous valid setting in use.
- R5: In every frame, mosi carries 16 bits MSB first, read at the 16 sclk rises. The order is 0 (don't-care), 0, chan[2], chan[1], chan[0], ref_sel, pm[1], pm[0], followed by eight 0 bits.
- R6: mosi changes only in the cycle after start is accepted and at sclk falling edges. It never changes at an sclk rise.
- R7: miso is sampled at each of the 16 sclk rises. result is the last 12 bits sampled, the first sampled bit being the most significant of all 16. The first four sampled bits have no effect on result.
- R8: done is a one-cycle pulse in the same cycle that cs_n rises. result, res_chan and res_tag_valid update with done and hold until the next done.
- R9: res_chan is the channel sent in the previous frame. res_tag_valid is 0 for the first frame after reset and 1 for every frame after it.
- R10: After each frame, cs_n stays high and busy stays 1 for 2*D cycles. busy is 1 from the cycle after acceptance until the end of that gap. A new frame may start at the first start sampled after busy falls.
- R11: start, next_chan, ref_sel, pwr_mode and half_div have no effect while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame |
| next_chan | input | 3 | Channel to write for the next conversion |
| ref_sel | input | 1 | Reference-select bit of the control word |
| pwr_mode | input | 2 | Power-mode bits of the control word |
| half_div | input | DIV_W | Serial clock half-period in system clocks |
| miso | input | 1 | Converter data-out line |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Converter data-in line |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 12 | Converted value |
| res_chan | output | 3 | Channel that produced result |
| res_tag_valid | output | 1 | res_chan is meaningful |

## Verification
The frames use half-periods of 1, 2, 3 and the maximum, so any phase-length or edge-counting error moves a visible edge. Divider values of 0 and 200 are applied to show that the previous setting is kept, and a frame right after a mid-test reset shows the default half-period and the invalid first tag. The returned words include all ones, a single low bit, a single high bit and a word with ones in the leading positions, which separates bit-order and off-by-one capture errors from leakage of the leading bits. One frame holds start high and changes the channel mid-frame, and frames are issued back to back at the earliest legal cycle to check the gap and the one-frame-late tagging.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int FRAME_LEN = 16;
  localparam int CTRL_LEN  = 8;
  localparam int RES_LEN   = 12;
  localparam int CH_W      = 3;
  localparam int PM_W      = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL,
    ST_GAP
  } phase_t;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            ref_sel;
    logic [PM_W-1:0] pm;
  } ctrl_t;

  // Full outgoing frame: two fixed zero bits, the control fields, then zero padding.
  function automatic logic [FRAME_LEN-1:0] pack_ctrl(input ctrl_t c);
    return {2'b00, c.chan, c.ref_sel, c.pm, {(FRAME_LEN-CTRL_LEN){1'b0}}};
  endfunction
endpackage

// File: rtl/sadc_divider.sv
module sadc_divider #(
  parameter int DIV_W    = 8,
  parameter int MAX_HALF = 195
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] half_req,
  input  logic             run,
  output logic             tick,
  output logic [DIV_W-1:0] half_q
);
  logic [DIV_W-1:0] cnt_q;
  logic             req_ok;

  assign req_ok = (half_req != '0) && (32'(half_req) <= MAX_HALF);
  assign tick   = run && (cnt_q == (half_q - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst)                 half_q <= DIV_W'(MAX_HALF);
    else if (load && req_ok) half_q <= half_req;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < half_q));
  // R4
  half_range_chk: assert property (@(posedge clk) disable iff (rst)
    (half_q != '0) && (32'(half_q) <= MAX_HALF));
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int TX_LEN = 16,
  parameter int RX_LEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TX_LEN-1:0] load_word,
  input  logic              shift_out,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [RX_LEN-1:0] rx_q
);
  logic [TX_LEN-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      mosi <= load_word[TX_LEN-1];
      tx_q <= load_word << 1;
    end else if (shift_out) begin
      mosi <= tx_q[TX_LEN-1];
      tx_q <= tx_q << 1;
    end
  end

  // Only the last RX_LEN bits survive; leading bits fall off the top.
  always_ff @(posedge clk) begin
    if (rst || load) rx_q <= '0;
    else if (sample) rx_q <= {rx_q[RX_LEN-2:0], miso};
  end

  // R6
  mosi_chg_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> $past(load || shift_out));
endmodule

// File: rtl/sadc_tagger.sv
module sadc_tagger #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [CH_W-1:0] req_chan,
  output logic [CH_W-1:0] tag_chan,
  output logic            tag_valid
);
  logic [CH_W-1:0] prev_chan;
  logic            prev_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_chan  <= '0;
      prev_valid <= 1'b0;
      tag_chan   <= '0;
      tag_valid  <= 1'b0;
    end else if (capture) begin
      tag_chan   <= prev_chan;
      tag_valid  <= prev_valid;
      prev_chan  <= req_chan;
      prev_valid <= 1'b1;
    end
  end

  // R9
  tag_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && prev_valid) |=> tag_valid);
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int LIMIT_CYCLES = 6250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CH_W-1:0]    next_chan,
  input  logic               ref_sel,
  input  logic [PM_W-1:0]    pwr_mode,
  input  logic [DIV_W-1:0]   half_div,
  input  logic               miso,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               busy,
  output logic               done,
  output logic [RES_LEN-1:0] result,
  output logic [CH_W-1:0]    res_chan,
  output logic               res_tag_valid
);
  localparam int MAX_HALF  = LIMIT_CYCLES / (2 * FRAME_LEN);
  localparam int EDGE_W    = $clog2(2 * FRAME_LEN);
  localparam int LAST_FALL = 2 * FRAME_LEN - 2;

  phase_t             st_q;
  logic [EDGE_W-1:0]  ecnt_q;
  logic               tick;
  logic [DIV_W-1:0]   half_q;
  logic               accept;
  logic               run;
  logic               rise_en;
  logic               fall_en;
  ctrl_t              ctrl;
  logic [FRAME_LEN-1:0] tx_word;
  logic [RES_LEN-1:0] rx_bits;
  logic [CH_W-1:0]    tag_chan;
  logic               tag_valid;

  assign accept  = (st_q == ST_IDLE) && start;
  assign run     = (st_q != ST_IDLE);
  assign busy    = run;
  assign rise_en = tick && ((st_q == ST_LEAD) || ((st_q == ST_RUN) && ecnt_q[0]));
  assign fall_en = tick && (st_q == ST_RUN) && !ecnt_q[0];

  always_comb begin
    ctrl.chan    = next_chan;
    ctrl.ref_sel = ref_sel;
    ctrl.pm      = pwr_mode;
    tx_word      = pack_ctrl(ctrl);
  end

  sadc_divider #(.DIV_W(DIV_W), .MAX_HALF(MAX_HALF)) u_div (
    .clk(clk), .rst(rst), .load(accept), .half_req(half_div),
    .run(run), .tick(tick), .half_q(half_q)
  );

  sadc_shifter #(.TX_LEN(FRAME_LEN), .RX_LEN(RES_LEN)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .load_word(tx_word),
    .shift_out(fall_en), .sample(rise_en), .miso(miso),
    .mosi(mosi), .rx_q(rx_bits)
  );

  sadc_tagger #(.CH_W(CH_W)) u_tag (
    .clk(clk), .rst(rst), .capture(accept), .req_chan(next_chan),
    .tag_chan(tag_chan), .tag_valid(tag_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      ecnt_q        <= '0;
      cs_n          <= 1'b1;
      sclk          <= 1'b0;
      done          <= 1'b0;
      result        <= '0;
      res_chan      <= '0;
      res_tag_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            cs_n <= 1'b0;
            st_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sclk   <= 1'b1;
            ecnt_q <= '0;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sclk   <= ecnt_q[0];
            ecnt_q <= ecnt_q + EDGE_W'(1);
            if (ecnt_q == EDGE_W'(LAST_FALL)) st_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n          <= 1'b1;
            done          <= 1'b1;
            result        <= rx_bits;
            res_chan      <= tag_chan;
            res_tag_valid <= tag_valid;
            ecnt_q        <= '0;
            st_q          <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (ecnt_q[0]) st_q <= ST_IDLE;
            ecnt_q <= ecnt_q + EDGE_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R2
  sclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> !cs_n);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));
  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> (cs_n && busy));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(cs_n) && !cs_n) |=> $stable(half_q));
endmodule

// File: tb/sadc_host_test.sv
`timescale 1ns/1ps
module sadc_host_test;
  localparam int DW    = 8;
  localparam int LIMIT = 6250;
  localparam int HMAX  = LIMIT / 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    next_chan = '0;
  logic          ref_sel = 1'b0;
  logic [1:0]    pwr_mode = '0;
  logic [DW-1:0] half_div = 8'd1;
  logic          miso = 1'b0;
  logic          cs_n, sclk, mosi, busy, done, res_tag_valid;
  logic [11:0]   result;
  logic [2:0]    res_chan;

  sadc_host #(.DIV_W(DW), .LIMIT_CYCLES(LIMIT)) uut (
    .clk(clk), .rst(rst), .start(start), .next_chan(next_chan),
    .ref_sel(ref_sel), .pwr_mode(pwr_mode), .half_div(half_div),
    .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
    .done(done), .result(result), .res_chan(res_chan),
    .res_tag_valid(res_tag_valid)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int k = -1, dref = HMAX, dcur = HMAX, nf = 0;
  logic [15:0] wref = '0, pref = '0, pat = '0;
  logic [2:0]  prev_ch = '0, tag_ch = '0, exp_ch = '0;
  logic        prev_v = 1'b0, tag_v = 1'b0, exp_v = 1'b0;
  logic [11:0] exp_res = '0;
  logic        sl = 1'b0, last_mosi = 1'b0;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Reference model: advances on each clock from the requirements.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      k = -1; dref = HMAX; prev_v = 1'b0; prev_ch = '0;
      exp_res = '0; exp_ch = '0; exp_v = 1'b0;
    end else if (k < 0) begin
      if (start) begin
        if (int'(half_div) >= 1 && int'(half_div) <= HMAX) dref = int'(half_div); // R4
        dcur   = dref;
        k      = 0;
        wref   = {2'b00, next_chan, ref_sel, pwr_mode, 8'h00};
        pref   = pat;
        tag_ch = prev_ch; tag_v = prev_v;
        prev_ch = next_chan; prev_v = 1'b1;
      end
    end else begin
      k++;
      if (k == 33 * dcur) begin
        exp_res = pref[11:0]; exp_ch = tag_ch; exp_v = tag_v;
      end
      if (k == 35 * dcur) k = -1;
    end
  end

  // Compare every cycle, then play the converter's data-out line.
  always @(negedge clk) begin
    if (cyc > 0) begin
      logic act;
      act = (k >= 0);
      chk("R2/R11 cs_n", 16'(cs_n), 16'(!(act && k < 33 * dcur)));
      chk("R3/R4 sclk", 16'(sclk), 16'(act && k < 32 * dcur && ((k / dcur) % 2 == 1)));
      chk("R5 mosi", 16'(mosi),
          16'((act && k < 32 * dcur) ? wref[15 - k / (2 * dcur)] : 1'b0));
      if (sclk && !sl) chk("R6 mosi at rise", 16'(mosi), 16'(last_mosi));
      chk("R8 done", 16'(done), 16'(act && k == 33 * dcur));
      chk("R10 busy", 16'(busy), 16'(act));
      chk("R7 result", 16'(result), 16'(exp_res));
      chk("R9 res_chan", 16'(res_chan), 16'(exp_ch));
      chk("R9 tag valid", 16'(res_tag_valid), 16'(exp_v));
    end
    if (cs_n) nf = 0;
    else if (sl && !sclk) nf++;
    sl = sclk;
    last_mosi = mosi;
    miso = (!cs_n && nf < 16) ? pref[15 - nf] : 1'b0;
  end

  task automatic frame(input logic [2:0] ch, input logic rs, input logic [1:0] pm,
                       input int hd, input logic [15:0] p, input bit hold);
    while (k >= 0) @(negedge clk);
    next_chan = ch; ref_sel = rs; pwr_mode = pm; half_div = hd[DW-1:0]; pat = p;
    start = 1'b1;
    @(negedge clk);
    if (hold) begin
      // R11: new requests while busy must change nothing
      next_chan = 3'd6; ref_sel = ~rs; pwr_mode = ~pm; half_div = 8'd7;
    end else begin
      start = 1'b0;
    end
    while (k >= 0) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 16'(cs_n), 16'h1);
    chk("R1 sclk", 16'(sclk), 16'h0);
    chk("R1 mosi", 16'(mosi), 16'h0);
    chk("R1 busy/done", 16'({busy, done}), 16'h0);
    chk("R1 result", 16'(result), 16'h0);
    chk("R1 tag", 16'({res_chan, res_tag_valid}), 16'h0);

    frame(3'd5, 1'b1, 2'b01, 2,   16'h0ABC, 1'b0);
    frame(3'd3, 1'b0, 2'b10, 1,   16'h0FFF, 1'b1);
    frame(3'd7, 1'b1, 2'b11, 0,   16'hF555, 1'b0); // R4 zero refused, R7 leading bits
    frame(3'd0, 1'b0, 2'b00, 200, 16'h0FFE, 1'b0); // R4 too slow refused
    frame(3'd2, 1'b1, 2'b00, 3,   16'h0800, 1'b0);
    frame(3'd1, 1'b0, 2'b10, 1,   16'h0001, 1'b0); // R10 back to back
    frame(3'd4, 1'b1, 2'b01, 1,   16'h0123, 1'b0);
    frame(3'd6, 1'b0, 2'b01, HMAX, 16'h07E1, 1'b0);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    frame(3'd4, 1'b0, 2'b00, 0,   16'h0456, 1'b0); // R4 default, R9 invalid tag
    frame(3'd2, 1'b1, 2'b11, 2,   16'h0A5A, 1'b0);
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule